// File: doc/BRIEF.md
# Odd-Parity SECDED Byte Codec

This block protects a data byte with a single-error-correcting, double-error-detecting code. The encoder path takes an 8-bit byte and produces a 13-bit codeword. That codeword has four Hamming check bits at the power-of-two positions, an overall parity bit at position 0, and the eight data bits in the remaining slots. Every parity group uses odd parity, so an all-zero word is never a valid codeword.

The checker path takes a 13-bit word that may have been corrupted on the way. It forms the four-bit syndrome from the failing checks and tests the overall parity. From these it returns the corrected byte, a single-error flag, a double-error flag and the index of the failing bit position.

Both paths are independent and registered once, so each result appears one clock after its input. The data width is a parameter, and the check-bit count and codeword width are derived from it.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit i carries position i. Positions 1, 2, 4 and 8 hold check bits. Data bits sit at the other positions with data[7] at 3, data[6] at 5, data[5] at 6, data[4] at 7, data[3] at 9, data[2] at 10, data[1] at 11 and data[0] at 12; byte 8'h6B encodes to 13'b1101001100101.
- R2: Check bit at position 2^k is chosen so that all positions whose index has bit k set, the check bit included, hold an odd number of ones.
- R3: Bit 0 is chosen so that all 13 codeword bits together hold an odd number of ones.
- R4: Encoder and checker outputs are registered: an input presented before a rising edge appears at the outputs after that edge and not before.
- R5: Reset is synchronous and active low; while it is sampled low, every output becomes zero.
- R6: A valid codeword returns its byte with both flags low and position 0.
- R7: A word with one flipped bit at position 1 to 12 returns the original byte, single flag high, double flag low, and the flipped position on the position output (the failing checks read as a binary number, bit k from check 2^k).
- R8: A word with only bit 0 flipped returns the byte unchanged with the single flag high and position 0.
- R9: A word with two flipped bits raises the double flag, keeps the single flag low, reports position 0, and passes the data bits out as received, without correction.
- R10: The single and double flags are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_data_i | input | 8 | Byte to encode |
| enc_word_o | output | 13 | Codeword, bit i is position i |
| chk_word_i | input | 13 | Received word to check |
| chk_data_o | output | 8 | Corrected byte |
| chk_single_o | output | 1 | One bit was in error and has been repaired |
| chk_double_o | output | 1 | Two bits were in error, uncorrectable |
| chk_pos_o | output | 4 | Index of the repaired position, 0 otherwise |

## Verification
The bench encodes all 256 bytes and feeds each codeword back with no flip, with each of the 13 single flips and with each of the 78 double flips. It also runs the two worked encode and decode values. An inverted check polarity makes clean words report errors. A wrong slot order breaks the worked codeword. A P0 error mistaken for a data error would corrupt a byte on R8. Correcting on a double error would alter the passed-through data, and resetting asynchronously or not at all shows in the reset-phase checks.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the SECDED codec: check-bit count, data slot
// positions and parity-group cover masks. Assumes codewords of at most
// 64 bits.
package secded_pkg;

    // Number of Hamming check bits needed for a data width.
    function automatic int chk_bits(input int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // True when p is a power of two (a check-bit position).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Codeword position of data slot n (slot 0 is the lowest position).
    function automatic int slot_pos(input int slot);
        int p;
        int n;
        p = 0;
        n = -1;
        while (n < slot) begin
            p++;
            if (!is_pow2(p)) n++;
        end
        return p;
    endfunction

    // Positions 1..cw-1 whose index has bit k set.
    function automatic logic [63:0] cover_mask(input int k, input int cw);
        logic [63:0] m;
        m = '0;
        for (int p = 1; p < cw; p++) begin
            if (((p >> k) & 1) == 1) m[p] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_encode.sv
`timescale 1ns/1ps
// Combinational odd-parity SECDED encoder. Places data bits in the
// non-power-of-two positions (MSB first), computes one check bit per
// power-of-two position and an overall parity bit at position 0.
module secded_encode
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   word_o
);

    logic [CW_W-1:0]  placed;
    logic [CHK_W-1:0] chk;
    logic [CW_W-1:0]  with_chk;

    // Data slots, MSB in the lowest data position.
    for (genvar j = 0; j < DATA_W; j++) begin : g_slot
        localparam int POS = slot_pos(j);
        assign placed[POS] = data_i[DATA_W-1-j];
    end

    // Check and overall positions start empty.
    for (genvar p = 0; p < CW_W; p++) begin : g_hole
        if (p == 0 || is_pow2(p)) begin : g_zero
            assign placed[p] = 1'b0;
        end
    end

    // One odd-parity check bit per group.
    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [CW_W-1:0] COVER = CW_W'(cover_mask(k, CW_W));
        assign chk[k] = ~^(placed & COVER);
    end

    // Merge check bits into their positions.
    always_comb begin
        with_chk = placed;
        for (int k = 0; k < CHK_W; k++) with_chk[1 << k] = chk[k];
    end

    // Overall bit makes the whole word odd.
    assign word_o = {with_chk[CW_W-1:1], ~^with_chk[CW_W-1:1]};

endmodule

// File: rtl/secded_syndrome.sv
`timescale 1ns/1ps
// Combinational syndrome generator. A check fails when its group holds
// an even number of ones; the overall test fails when the whole word
// does.
module secded_syndrome
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic [CW_W-1:0]  word_i,
    output logic [CHK_W-1:0] synd_o,
    output logic             all_bad_o
);

    // One failing-check bit per group.
    for (genvar k = 0; k < CHK_W; k++) begin : g_synd
        localparam logic [CW_W-1:0] COVER = CW_W'(cover_mask(k, CW_W));
        assign synd_o[k] = ~^(word_i & COVER);
    end

    // Overall odd-parity test.
    assign all_bad_o = ~^word_i;

endmodule

// File: rtl/secded_correct.sv
`timescale 1ns/1ps
// Combinational classifier and corrector. Wrong overall parity means a
// single error at the syndrome position (0 = overall bit); a non-zero
// syndrome with good overall parity means a double error, left
// uncorrected.
module secded_correct
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic [CW_W-1:0]   word_i,
    input  logic [CHK_W-1:0]  synd_i,
    input  logic              all_bad_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o,
    output logic [CHK_W-1:0]  pos_o
);

    logic [CW_W-1:0] flip;
    logic [CW_W-1:0] fixed;

    // One-hot flip mask at the syndrome position on a single error.
    always_comb begin
        for (int p = 0; p < CW_W; p++) begin
            flip[p] = all_bad_i && (synd_i == CHK_W'(p));
        end
    end

    assign fixed = word_i ^ flip;

    // Pull data back out of its slots.
    for (genvar j = 0; j < DATA_W; j++) begin : g_slot
        localparam int POS = slot_pos(j);
        assign data_o[DATA_W-1-j] = fixed[POS];
    end

    // Classification outputs.
    assign single_o = all_bad_i;
    assign double_o = !all_bad_i && (|synd_i);
    assign pos_o    = all_bad_i ? synd_i : '0;

endmodule

// File: rtl/secded_codec.sv
`timescale 1ns/1ps
// Top of the SECDED codec: an encoder path and an independent checker
// path, each with one register stage. Synchronous active-low reset
// clears every output.
module secded_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CW_W-1:0]   enc_word_o,
    input  logic [CW_W-1:0]   chk_word_i,
    output logic [DATA_W-1:0] chk_data_o,
    output logic              chk_single_o,
    output logic              chk_double_o,
    output logic [CHK_W-1:0]  chk_pos_o
);

    logic [CW_W-1:0]   enc_word;
    logic [CHK_W-1:0]  synd;
    logic              all_bad;
    logic [DATA_W-1:0] fix_data;
    logic              fix_single;
    logic              fix_double;
    logic [CHK_W-1:0]  fix_pos;

    secded_encode #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word)
    );

    secded_syndrome #(.DATA_W(DATA_W)) u_syn (
        .word_i    (chk_word_i),
        .synd_o    (synd),
        .all_bad_o (all_bad)
    );

    secded_correct #(.DATA_W(DATA_W)) u_fix (
        .word_i    (chk_word_i),
        .synd_i    (synd),
        .all_bad_i (all_bad),
        .data_o    (fix_data),
        .single_o  (fix_single),
        .double_o  (fix_double),
        .pos_o     (fix_pos)
    );

    // Register the encoder result.
    always_ff @(posedge clk) begin
        if (!rst_n) enc_word_o <= '0;
        else        enc_word_o <= enc_word;
    end

    // Register the checker results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_data_o   <= '0;
            chk_single_o <= 1'b0;
            chk_double_o <= 1'b0;
            chk_pos_o    <= '0;
        end else begin
            chk_data_o   <= fix_data;
            chk_single_o <= fix_single;
            chk_double_o <= fix_double;
            chk_pos_o    <= fix_pos;
        end
    end

endmodule

// File: rtl/secded_codec_chk.sv
`timescale 1ns/1ps
// Property checker for secded_codec, attached by bind. Observes ports
// only.
module secded_codec_chk
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CW_W-1:0]   enc_word_o,
    input logic [CW_W-1:0]   chk_word_i,
    input logic [DATA_W-1:0] chk_data_o,
    input logic              chk_single_o,
    input logic              chk_double_o,
    input logic [CHK_W-1:0]  chk_pos_o
);

    // R3: a codeword registered out of reset has odd overall parity.
    p_enc_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (^enc_word_o) == 1'b1);

    // R5: reset sampled low clears every output on the next edge.
    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |=> (enc_word_o == '0 && chk_data_o == '0 && !chk_single_o
                    && !chk_double_o && chk_pos_o == '0));

    // R6: a received word with odd overall parity is never a single error.
    p_odd_no_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (^chk_word_i) == 1'b1) |=> !chk_single_o);

    // R9: a word with even overall parity is never reported as double.
    p_even_no_double_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (^chk_word_i) == 1'b0) |=> !chk_double_o);

    // R10: the two error flags are exclusive.
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_single_o && chk_double_o));

    // R9: position is zero unless a single error was repaired.
    p_pos_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_single_o |-> chk_pos_o == '0);

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_data_i   (enc_data_i),
    .enc_word_o   (enc_word_o),
    .chk_word_i   (chk_word_i),
    .chk_data_o   (chk_data_o),
    .chk_single_o (chk_single_o),
    .chk_double_o (chk_double_o),
    .chk_pos_o    (chk_pos_o)
);

// File: tb/tb_secded_codec.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference, exhaustive flips, reset.
module tb_secded_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic [12:0] enc_word_o;
    logic [12:0] chk_word_i = '0;
    logic [7:0]  chk_data_o;
    logic        chk_single_o;
    logic        chk_double_o;
    logic [3:0]  chk_pos_o;

    int checks = 0;
    int failures = 0;
    logic [12:0] prev_enc = '0;

    always #2 clk = ~clk;

    secded_codec dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data_i),
        .enc_word_o   (enc_word_o),
        .chk_word_i   (chk_word_i),
        .chk_data_o   (chk_data_o),
        .chk_single_o (chk_single_o),
        .chk_double_o (chk_double_o),
        .chk_pos_o    (chk_pos_o)
    );

    // Reference: position of data slot n, skipping powers of two.
    function automatic int ref_pos(input int slot);
        int n = -1;
        int p = 0;
        while (n < slot) begin
            p++;
            if ($countones(p) != 1) n++;
        end
        return p;
    endfunction

    // Reference encoder by counting ones per group.
    function automatic logic [12:0] ref_encode(input logic [7:0] d);
        logic [12:0] w = '0;
        int ones;
        for (int s = 0; s < 8; s++) w[ref_pos(s)] = d[7-s];
        for (int k = 0; k < 4; k++) begin
            ones = 0;
            for (int p = 1; p < 13; p++)
                if (((p >> k) & 1) == 1 && p != (1 << k)) ones += int'(w[p]);
            w[1 << k] = (ones % 2 == 0);
        end
        w[0] = ($countones(w[12:1]) % 2 == 0);
        return w;
    endfunction

    // Reference raw data extraction.
    function automatic logic [7:0] ref_extract(input logic [12:0] w);
        logic [7:0] d;
        for (int s = 0; s < 8; s++) d[7-s] = w[ref_pos(s)];
        return d;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, compare one cycle later.
    task automatic apply(input logic [7:0] d, input logic [12:0] w,
                         input logic [7:0] e_data, input bit e_single,
                         input bit e_double, input logic [3:0] e_pos,
                         input string tag);
        logic [12:0] e_enc;
        @(negedge clk);
        enc_data_i = d;
        chk_word_i = w;
        #1;
        check(enc_word_o == prev_enc, "R4 output moved before edge",
              32'(enc_word_o), 32'(prev_enc));
        e_enc = ref_encode(d);
        @(negedge clk);
        check(enc_word_o == e_enc, "R1 R2 R3 codeword", 32'(enc_word_o), 32'(e_enc));
        check(chk_data_o == e_data, {tag, " data"}, 32'(chk_data_o), 32'(e_data));
        check(chk_single_o == e_single, {tag, " single"}, 32'(chk_single_o), 32'(e_single));
        check(chk_double_o == e_double, {tag, " double"}, 32'(chk_double_o), 32'(e_double));
        check(chk_pos_o == e_pos, {tag, " position"}, 32'(chk_pos_o), 32'(e_pos));
        check(!(chk_single_o && chk_double_o), "R10 flags exclusive",
              32'({chk_single_o, chk_double_o}), 32'(0));
        prev_enc = e_enc;
    endtask

    task automatic check_zero(input string tag);
        check(enc_word_o == '0, {tag, " enc"}, 32'(enc_word_o), 32'(0));
        check({chk_data_o, chk_single_o, chk_double_o, chk_pos_o} == '0, {tag, " chk"},
              32'({chk_data_o, chk_single_o, chk_double_o, chk_pos_o}), 32'(0));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [12:0] cw;
        // R5: reset with busy inputs.
        enc_data_i = 8'hA5;
        chk_word_i = 13'h1FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("R5 reset");
        rst_n = 1'b1;
        prev_enc = ref_encode(8'hA5);
        @(negedge clk);

        // R1: worked encode value.
        apply(8'h6B, 13'b1101001100101, 8'h6B, 1'b0, 1'b0, 4'd0, "R6 clean");
        check(enc_word_o == 13'b1101001100101, "R1 worked codeword",
              32'(enc_word_o), 32'(13'b1101001100101));

        // R7: worked decode value, error at position 6.
        apply(8'h1D, 13'b1011011010110, 8'h1D, 1'b1, 1'b0, 4'd6, "R7 worked");

        // Exhaustive sweep of bytes, single and double flips.
        for (int d = 0; d < 256; d++) begin
            cw = ref_encode(d[7:0]);
            apply(d[7:0], cw, d[7:0], 1'b0, 1'b0, 4'd0, "R6 clean");
            for (int q = 0; q < 13; q++) begin
                apply(d[7:0], cw ^ (13'd1 << q), d[7:0], 1'b1, 1'b0, 4'(q),
                      (q == 0) ? "R8 overall flip" : "R7 single flip");
            end
            for (int a = 0; a < 13; a++) begin
                for (int b = a + 1; b < 13; b++) begin
                    logic [12:0] bad;
                    bad = cw ^ (13'd1 << a) ^ (13'd1 << b);
                    apply(d[7:0], bad, ref_extract(bad), 1'b0, 1'b1, 4'd0,
                          "R9 double flip");
                end
            end
        end

        // R5: reset mid-run, synchronous.
        @(negedge clk);
        enc_data_i = 8'h3C;
        chk_word_i = 13'h0F0F;
        rst_n = 1'b0;
        #1;
        check(enc_word_o == prev_enc, "R5 reset is synchronous",
              32'(enc_word_o), 32'(prev_enc));
        @(negedge clk);
        check_zero("R5 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule